// File: doc/BRIEF.md
# I2C Master Serial Clock Generator

This block produces the serial clock timing for an I2C bus master. It derives everything from the peripheral clock in two stages. A 5-bit programmable prescaler emits a reference tick once every `p` clocks. A 3-bit selector `n` then sets how many ticks make up each half of the serial clock. One undisturbed serial clock period is `p × (2^(n+2) + 16)` peripheral clocks. The high and low halves are equal. The same tick also paces a noise filter on the sampled SCL line. The tick period is therefore the filter width, and a legal setup keeps it above 50 ns and no longer than 150 ns.

The controller raises `xfer_active` for the length of a transfer. While it is low, the block leaves SCL released, keeps its phase counter at zero and copies the two setting fields into shadow registers. While it is high, the block uses only the shadow copies, so a write during a transfer cannot disturb the running period. The block follows clock synchronization. The high half finishes its count only once the filtered SCL line has actually been seen high, so another device holding SCL low lengthens the period.

Top module: `i2c_scl_clkgen`

## Requirements
- R1: After reset the tick divisor is 1, so `presc_tick` is high in every clock, and `scl_drive_low` is low.
- R2: The prescaler code selects the divisor p. Code 0 means 32. Any other code means its own binary value, so 1 means 1 and 13 means 13. `presc_tick` is high for one clock in every p clocks.
- R3: With `xfer_active` high, each low phase of the serial clock, in which `scl_drive_low` is high, lasts `(2^(n+1)+8) × p` clocks.
- R4: When no other device holds SCL low, each high phase also lasts `(2^(n+1)+8) × p` clocks. The full period is therefore `p × (2^(n+2)+16)` clocks, which is 20 clocks for n=0 and 528 clocks for n=7 at p=1.
- R5: A high phase ends only once the filtered SCL line is high. While SCL is held low externally, `scl_drive_low` stays low and the next low phase is deferred.
- R6: The prescaler and divider fields are captured only while `xfer_active` is low. Changing them while it is high leaves the serial clock timing unchanged.
- R7: While `xfer_active` is low, `scl_drive_low` is low and the phase counter is zero. When `xfer_active` rises, the block starts with a low phase.
- R8: A change on the SCL input reaches the filtered level only after the new value has been seen at two consecutive prescaler ticks. A pulse shorter than one tick has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| presc_code | input | 5 | Prescaler code (0 means divide by 32) |
| div_sel | input | 3 | Serial clock divider selector n |
| xfer_active | input | 1 | High while a transfer is running |
| scl_in | input | 1 | Sampled level of the SCL line |
| scl_drive_low | output | 1 | Request to pull SCL low |
| presc_tick | output | 1 | Prescaler reference tick strobe |

## Verification
A cycle-level model in the bench follows both outputs under several setups. Prescaler codes 1, 5, 13 and 0 separate the zero-means-32 rule from plain binary decoding. Divider settings 0, 1 and 7 tell the exponential term apart from the constant 16. A setting change made mid-transfer shows whether the shadow copies really hold. An external hold on SCL separates correct stretching from a free-running counter. A one-clock release pulse during that hold, with p = 8, shows whether the filter can be defeated by a glitch. A disable followed by a re-enable checks that the block restarts with a clean low phase.

// File: rtl/i2c_clk_pkg.sv
package i2c_clk_pkg;
   typedef enum logic {PH_LOW = 1'b0, PH_HIGH = 1'b1} scl_phase_e;
endpackage

// File: rtl/scl_prescaler.sv
module scl_prescaler #(
   parameter int PRESC_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [PRESC_W:0] divisor,
   output logic             tick
);
   logic [PRESC_W-1:0] cnt;
   logic [PRESC_W:0]   cnt_ext;

   assign cnt_ext = {1'b0, cnt};
   // wraps even if a smaller divisor was loaded while the count was high
   assign tick    = (cnt_ext >= divisor - 1'b1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cnt <= '0;
      else if (tick) cnt <= '0;
      else           cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/scl_noise_filter.sv
module scl_noise_filter (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic line_raw,
   output logic line_flt
);
   logic cand;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cand     <= 1'b1;
         line_flt <= 1'b1;
      end else if (tick) begin
         cand <= line_raw;
         if (line_raw == cand) line_flt <= line_raw;
      end
   end

   // R8
   flt_moves_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(line_flt) |-> $past(tick));
endmodule

// File: rtl/scl_phase_gen.sv
module scl_phase_gen
   import i2c_clk_pkg::*;
#(
   parameter int DIV_W     = 3,
   parameter int HALF_BASE = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             enable,
   input  logic             tick,
   input  logic [DIV_W-1:0] n_sel,
   input  logic             line_hi,
   output logic             drive_low
);
   localparam int HALF_W = (1 << DIV_W) + 1;

   scl_phase_e        phase;
   logic [HALF_W-1:0] cnt;
   logic [HALF_W-1:0] half_len;
   logic [DIV_W:0]    shamt;
   logic              last;

   assign shamt     = {1'b0, n_sel} + 1'b1;
   assign half_len  = HALF_W'(HALF_BASE) + (HALF_W'(1) << shamt);
   assign last      = (cnt == half_len - 1'b1);
   assign drive_low = enable && (phase == PH_LOW);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase <= PH_LOW;
         cnt   <= '0;
      end else if (!enable) begin
         phase <= PH_LOW;
         cnt   <= '0;
      end else if (tick) begin
         if (!last) begin
            cnt <= cnt + 1'b1;
         end else if (phase == PH_LOW) begin
            phase <= PH_HIGH;
            cnt   <= '0;
         end else if (line_hi) begin
            phase <= PH_LOW;
            cnt   <= '0;
         end
      end
   end

   // R3
   phase_edge_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(enable) && !$stable(phase)) |-> $past(tick));
   // R5
   high_ends_when_seen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(enable) && $past(phase) == PH_HIGH && phase == PH_LOW) |-> $past(line_hi));
   // R7
   idle_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |=> (cnt == '0 && phase == PH_LOW));
endmodule

// File: rtl/i2c_scl_clkgen.sv
module i2c_scl_clkgen #(
   parameter int PRESC_W     = 5,
   parameter int DIV_W       = 3,
   parameter int HALF_BASE   = 8,
   parameter int SYNC_STAGES = 0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [PRESC_W-1:0] presc_code,
   input  logic [DIV_W-1:0]   div_sel,
   input  logic               xfer_active,
   input  logic               scl_in,
   output logic               scl_drive_low,
   output logic               presc_tick
);
   localparam logic [PRESC_W:0] P_MAX = (PRESC_W+1)'(1) << PRESC_W;

   initial begin
      assert (PRESC_W >= 1 && PRESC_W <= 8) else $fatal(1, "PRESC_W out of range");
      assert (DIV_W >= 1 && DIV_W <= 4)     else $fatal(1, "DIV_W out of range");
      assert (HALF_BASE >= 2)               else $fatal(1, "HALF_BASE too small");
      assert (SYNC_STAGES >= 0)             else $fatal(1, "SYNC_STAGES negative");
   end

   logic [PRESC_W:0]   p_sh;
   logic [DIV_W-1:0]   n_sh;
   logic [PRESC_W:0]   p_dec;
   logic               scl_sync;
   logic               scl_flt;

   assign p_dec = (presc_code == '0) ? P_MAX : {1'b0, presc_code};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         p_sh <= (PRESC_W+1)'(1);
         n_sh <= '0;
      end else if (!xfer_active) begin
         p_sh <= p_dec;
         n_sh <= div_sel;
      end
   end

   generate
      if (SYNC_STAGES == 0) begin : g_nosync
         assign scl_sync = scl_in;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] sr;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sr <= '1;
            else        sr <= {sr[SYNC_STAGES-2+((SYNC_STAGES==1)?1:0):0], scl_in};
         end
         assign scl_sync = sr[SYNC_STAGES-1];
      end
   endgenerate

   scl_prescaler #(.PRESC_W(PRESC_W)) u_presc (
      .clk(clk), .rst_n(rst_n), .divisor(p_sh), .tick(presc_tick));

   scl_noise_filter u_flt (
      .clk(clk), .rst_n(rst_n), .tick(presc_tick),
      .line_raw(scl_sync), .line_flt(scl_flt));

   scl_phase_gen #(.DIV_W(DIV_W), .HALF_BASE(HALF_BASE)) u_phase (
      .clk(clk), .rst_n(rst_n), .enable(xfer_active), .tick(presc_tick),
      .n_sel(n_sh), .line_hi(scl_flt), .drive_low(scl_drive_low));

   // R6
   shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_active && $past(xfer_active)) |-> ($stable(p_sh) && $stable(n_sh)));
endmodule

// File: tb/i2c_scl_clkgen_test.sv
module i2c_scl_clkgen_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [4:0] presc_code = 5'd1;
   logic [2:0] div_sel = 3'd0;
   logic       xfer_active = 1'b0;
   logic       ext_hold = 1'b0;
   logic       scl_in;
   logic       scl_drive_low;
   logic       presc_tick;

   int checks = 0, failures = 0, cycles = 0;
   string cur_req = "R1";

   assign scl_in = !(scl_drive_low || ext_hold);

   i2c_scl_clkgen uut (
      .clk(clk), .rst_n(rst_n), .presc_code(presc_code), .div_sel(div_sel),
      .xfer_active(xfer_active), .scl_in(scl_in),
      .scl_drive_low(scl_drive_low), .presc_tick(presc_tick));

   always #5ns clk = ~clk;

   // behavioural reference
   int m_pc = 0, m_p = 1, m_n = 0, m_cnt = 0;
   bit m_low = 1, m_f = 1, m_cand = 1;
   int run = 0, last_low = 0, last_high = 0;
   bit prev_drv = 0;

   function automatic int half_of(int n);
      return (2 ** (n + 1)) + 8;
   endfunction

   task automatic chk(bit ok, string req, int act, int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   always @(posedge clk) begin
      cycles++;
      if (!rst_n) begin
         m_pc = 0; m_p = 1; m_n = 0; m_cnt = 0; m_low = 1; m_f = 1; m_cand = 1;
      end else begin
         bit t, f_old;
         t = (m_pc >= m_p - 1);
         f_old = m_f;
         if (t) begin
            if (scl_in == m_cand) m_f = scl_in;
            m_cand = scl_in;
         end
         if (!xfer_active) begin
            m_low = 1; m_cnt = 0;
            m_p = (presc_code == 0) ? 32 : int'(presc_code);
            m_n = int'(div_sel);
         end else if (t) begin
            if (m_cnt != half_of(m_n) - 1) m_cnt++;
            else if (m_low) begin m_low = 0; m_cnt = 0; end
            else if (f_old) begin m_low = 1; m_cnt = 0; end
         end
         m_pc = t ? 0 : m_pc + 1;
      end
   end

   always @(negedge clk) begin
      if (rst_n) begin
         bit e_drv, e_tick;
         e_drv  = xfer_active && m_low;
         e_tick = (m_pc >= m_p - 1);
         chk(scl_drive_low == e_drv, {cur_req, " drive_low vs model"}, scl_drive_low, e_drv);
         chk(presc_tick == e_tick, {cur_req, " tick vs model"}, presc_tick, e_tick);
         if (scl_drive_low == prev_drv) run++;
         else begin
            if (prev_drv) last_low = run; else last_high = run;
            run = 1;
         end
         prev_drv = scl_drive_low;
      end
   end

   task automatic step(int k);
      repeat (k) @(posedge clk);
      #1;
   endtask

   task automatic wait_drv(bit v);
      do @(posedge clk); while (scl_drive_low != v);
      #1;
   endtask

   task automatic count_ticks(int win, int exp, string req);
      int n = 0;
      repeat (win) begin
         @(negedge clk);
         if (presc_tick) n++;
      end
      step(1);
      chk(n == exp, req, n, exp);
   endtask

   task automatic run_config(int code, int n, int settle);
      xfer_active = 0; presc_code = 5'(code); div_sel = 3'(n);
      step(3);
      xfer_active = 1;
      step(settle);
   endtask

   initial begin
      step(3);
      rst_n = 1;
      // R1: reset state
      repeat (4) begin
         @(negedge clk);
         chk(presc_tick == 1, "R1 tick after reset", presc_tick, 1);
         chk(scl_drive_low == 0, "R1 drive after reset", scl_drive_low, 0);
      end
      step(1);

      // R2: prescaler decoding
      cur_req = "R2";
      presc_code = 5'd0;  step(2); count_ticks(64, 2, "R2 code 0 means 32");
      presc_code = 5'd13; step(2); count_ticks(26, 2, "R2 code 13");
      presc_code = 5'd5;  step(2); count_ticks(20, 4, "R2 code 5");

      // R3 R4: phase lengths
      cur_req = "R3/R4";
      run_config(1, 0, 200);
      chk(last_low == 10, "R3 low n=0 p=1", last_low, 10);
      chk(last_high == 10, "R4 high n=0 p=1", last_high, 10);
      run_config(2, 7, 2600);
      chk(last_low == 528, "R3 low n=7 p=2", last_low, 528);
      chk(last_high == 528, "R4 high n=7 p=2", last_high, 528);
      run_config(0, 0, 1400);
      chk(last_low == 320, "R3 low n=0 p=32", last_low, 320);
      chk(last_high == 320, "R4 high n=0 p=32", last_high, 320);

      // R6: mid-transfer writes ignored
      cur_req = "R6";
      run_config(1, 1, 100);
      presc_code = 5'd3; div_sel = 3'd5;
      step(120);
      chk(last_low == 12, "R6 low unchanged", last_low, 12);
      chk(last_high == 12, "R6 high unchanged", last_high, 12);

      // R5: external stretch
      cur_req = "R5";
      wait_drv(1);
      ext_hold = 1;
      wait_drv(0);
      step(40);
      chk(scl_drive_low == 0, "R5 released during hold", scl_drive_low, 0);
      ext_hold = 0;
      wait_drv(1);
      step(1);
      chk(last_high > 40, "R5 high stretched", last_high, 41);

      // R8: glitch rejection during a hold, p=8
      cur_req = "R8";
      run_config(8, 0, 50);
      wait_drv(1);
      ext_hold = 1;
      wait_drv(0);
      step(150);
      ext_hold = 0;
      step(1);
      ext_hold = 1;
      repeat (30) begin
         @(negedge clk);
         chk(scl_drive_low == 0, "R8 glitch ignored", scl_drive_low, 0);
      end
      step(1);
      ext_hold = 0;
      step(200);
      chk(last_low == 80, "R8 resumes after hold", last_low, 80);

      // R7: disable and restart
      cur_req = "R7";
      run_config(1, 0, 5);
      xfer_active = 0;
      @(negedge clk);
      chk(scl_drive_low == 0, "R7 idle releases", scl_drive_low, 0);
      step(5);
      xfer_active = 1;
      @(negedge clk);
      chk(scl_drive_low == 1, "R7 restart low", scl_drive_low, 1);
      step(60);
      chk(last_low == 10, "R7 first low length", last_low, 10);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      wait (cycles > 150000);
      checks++; failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule